// File: doc/BRIEF.md
# Time-of-Day Counter with 12/24-Hour Display

This block keeps the time of day as hours, minutes and seconds and presents it as six BCD digits. Everything runs on one system clock. Time advances on a one-cycle enable, `tick_1hz`, which an external divider asserts once per second. The block has a single hour register. A mode input chooses whether that hour is shown on a 24-hour dial (00 to 23) or a 12-hour dial (01 to 12). Switching the mode changes only how the hour is shown, never the stored time.

For setting the clock, a run/set selector takes the minute and hour fields off the carry chain. In set mode these two fields step only on presses of their own buttons. Each button input passes through a two-flop synchronizer and a rising-edge detector, so a press held for any length of time gives exactly one step. A synchronous clear returns the time to midnight. A count enable freezes the time completely while it is low. An output pulse marks each top of the hour reached by normal counting.

Top module: `tod_counter`

## Requirements
- R1: Seconds and minutes are each two BCD digits running 00 to 59. A units digit at 9 wraps to 0 and steps the tens digit. A field at 59 wraps to 00. In run mode, the seconds wrap steps the minutes and the minutes wrap steps the hour.
- R2: With `mode_24` high, the hour digits show 00 to 23, and 23:59:59 followed by a tick gives 00:00:00.
- R3: With `mode_24` low, the hour digits show 01 to 12. Stored hours 0 and 12 both show as 12, so 11:59:59 rolls to 12:00:00 and 12:59:59 rolls to 01:00:00.
- R4: `mode_24` high selects the 24-hour dial and low selects the 12-hour dial. Changing it changes the hour digits in the same cycle without altering the stored time (stored hour 13 shows 13 or 01).
- R5: `clear` high, or `rst_n` low, at a clock edge sets all seconds and minutes digits to 0 and the stored hour to midnight. Midnight shows as 00 in 24-hour mode and 12 in 12-hour mode. Clear overrides a simultaneous tick or button step.
- R6: While `count_en` is low, neither ticks nor button presses change any digit.
- R7: In set mode (`set_mode` high), each press of `btn_min` or `btn_hour` advances its field by exactly one, however long the button is held. The new value appears after the third rising clock edge that samples the button high.
- R8: In set mode, ticks still advance the seconds, but the seconds wrap does not carry into the minutes. A manual minute step from 59 gives 00 without touching the hour. A manual hour step from 23 gives 00.
- R9: In run mode, presses of `btn_min` and `btn_hour` have no effect.
- R10: `hour_pulse` is high for exactly one cycle: the first cycle in which the display shows the new hour at :00:00 after counting from xx:59:59 in run mode. It stays low when the seconds wrap in set mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle enable, once per second |
| count_en | input | 1 | High allows the time to change |
| clear | input | 1 | Synchronous clear to midnight |
| mode_24 | input | 1 | 1 = 24-hour dial, 0 = 12-hour dial |
| set_mode | input | 1 | 1 = set mode (buttons), 0 = run mode (carries) |
| btn_min | input | 1 | Minute set button, asynchronous level |
| btn_hour | input | 1 | Hour set button, asynchronous level |
| sec_ones | output | 4 | Seconds units digit |
| sec_tens | output | 4 | Seconds tens digit |
| min_ones | output | 4 | Minutes units digit |
| min_tens | output | 4 | Minutes tens digit |
| hr_ones | output | 4 | Hours units digit |
| hr_tens | output | 4 | Hours tens digit |
| hour_pulse | output | 1 | One-cycle top-of-hour pulse |

## Verification
The assertions assume that `tick_1hz` and the button levels are synchronous to `clk` when they are sampled. They also assume that `clear`, `count_en`, `set_mode` and `mode_24` are ordinary synchronous levels. The properties judge any change of the digits against those inputs as sampled one edge earlier. The stimulus changes every input only on the falling clock edge and holds each button for several cycles and then releases it for several cycles, so every press passes cleanly through the synchronizer. The 59:59 boundaries are reached by setting the minutes and hours with button presses and the seconds with ticks taken in set mode, instead of counting through a whole day.

// File: rtl/tod_pkg.sv
// Package tod_pkg
// Shared widths and limits for the time-of-day counter.
// Assumes BCD digits of four bits each.
package tod_pkg;
    localparam int DIGIT_W       = 4;
    localparam int HOURS_PER_DAY = 24;
    localparam int SYNC_STAGES   = 2;
    typedef logic [DIGIT_W-1:0] bcd_t;
endpackage

// File: rtl/tod_btn_pulse.sv
// Module tod_btn_pulse
// Brings an asynchronous button level into the clock domain through STAGES
// flops and gives a one-cycle pulse on each rising edge of the result.
// Assumes the button is debounced elsewhere.
module tod_btn_pulse #(
    parameter int STAGES = tod_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    output logic pulse
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] shreg;

    // Purpose: shift the button level through synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[CHAIN-2:0], btn};
    end

    // Purpose: rising edge of the synchronized level.
    assign pulse = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/tod_bcd60.sv
// Module tod_bcd60
// Two-digit BCD counter from 00 to TENS_MAX/ONES_MAX, stepped by inc.
// at_max flags the last value so the parent can build its carry.
// Assumes clr has priority over inc.
module tod_bcd60
    import tod_pkg::*;
#(
    parameter int ONES_MAX = 9,
    parameter int TENS_MAX = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output bcd_t ones,
    output bcd_t tens,
    output logic at_max
);
    localparam bcd_t ONES_TOP = bcd_t'(ONES_MAX);
    localparam bcd_t TENS_TOP = bcd_t'(TENS_MAX);

    // Purpose: step the units digit and carry into the tens digit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ones <= '0;
            tens <= '0;
        end else if (inc) begin
            if (ones == ONES_TOP) begin
                ones <= '0;
                tens <= (tens == TENS_TOP) ? '0 : tens + 1'b1;
            end else begin
                ones <= ones + 1'b1;
            end
        end
    end

    // Purpose: flag the last value of the range.
    assign at_max = (ones == ONES_TOP) && (tens == TENS_TOP);
endmodule

// File: rtl/tod_hours.sv
// Module tod_hours
// Holds the hour as a binary count 0..HOURS-1 and shows it as two BCD
// digits, either directly (24-hour dial) or as 1..HOURS/2 (12-hour dial).
// Assumes clr has priority over inc.
module tod_hours
    import tod_pkg::*;
#(
    parameter int HOURS = HOURS_PER_DAY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic mode_24,
    output bcd_t ones,
    output bcd_t tens
);
    localparam int HW = $clog2(HOURS + 1);
    localparam logic [HW-1:0] LAST = HW'(HOURS - 1);
    localparam logic [HW-1:0] HALF = HW'(HOURS / 2);

    logic [HW-1:0] hcnt;
    logic [HW-1:0] shown;
    logic [HW-1:0] half_val;
    logic [HW-1:0] q10;
    logic [HW-1:0] r10;

    // Purpose: count stored hours and wrap at the end of the day.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  hcnt <= '0;
        else if (inc)       hcnt <= (hcnt == LAST) ? '0 : hcnt + 1'b1;
    end

    // Purpose: map the stored hour to the selected dial and split into BCD.
    always_comb begin
        half_val = (hcnt >= HALF) ? hcnt - HALF : hcnt;
        if (half_val == '0) half_val = HALF;
        shown = mode_24 ? hcnt : half_val;
        q10   = shown / HW'(10);
        r10   = shown - q10 * HW'(10);
    end

    assign tens = bcd_t'(q10);
    assign ones = bcd_t'(r10);
endmodule

// File: rtl/tod_counter.sv
// Module tod_counter
// Time-of-day counter: seconds, minutes and hours in BCD, advanced by a
// one-cycle tick enable, with a run/set selector, button setting,
// synchronous clear, count enable and a top-of-hour pulse.
// Assumes tick_1hz and the control levels are synchronous to clk.
module tod_counter
    import tod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1hz,
    input  logic count_en,
    input  logic clear,
    input  logic mode_24,
    input  logic set_mode,
    input  logic btn_min,
    input  logic btn_hour,
    output bcd_t sec_ones,
    output bcd_t sec_tens,
    output bcd_t min_ones,
    output bcd_t min_tens,
    output bcd_t hr_ones,
    output bcd_t hr_tens,
    output logic hour_pulse
);
    logic min_press;
    logic hour_press;
    logic sec_step;
    logic sec_last;
    logic min_step;
    logic min_last;
    logic hour_step;
    logic roll_hour;

    tod_btn_pulse u_min_btn (
        .clk   (clk),
        .rst_n (rst_n),
        .btn   (btn_min),
        .pulse (min_press)
    );

    tod_btn_pulse u_hour_btn (
        .clk   (clk),
        .rst_n (rst_n),
        .btn   (btn_hour),
        .pulse (hour_press)
    );

    // Purpose: steer ticks, carries and button pulses into the three fields.
    always_comb begin
        sec_step  = count_en & tick_1hz;
        roll_hour = ~set_mode & sec_step & sec_last & min_last;
        min_step  = count_en & (set_mode ? min_press  : (sec_step & sec_last));
        hour_step = count_en & (set_mode ? hour_press : roll_hour);
    end

    tod_bcd60 u_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clear),
        .inc    (sec_step),
        .ones   (sec_ones),
        .tens   (sec_tens),
        .at_max (sec_last)
    );

    tod_bcd60 u_min (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clear),
        .inc    (min_step),
        .ones   (min_ones),
        .tens   (min_tens),
        .at_max (min_last)
    );

    tod_hours u_hour (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clear),
        .inc     (hour_step),
        .mode_24 (mode_24),
        .ones    (hr_ones),
        .tens    (hr_tens)
    );

    // Purpose: register the top-of-hour pulse alongside the rollover.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) hour_pulse <= 1'b0;
        else                 hour_pulse <= roll_hour;
    end
endmodule

// File: rtl/tod_counter_chk.sv
// Module tod_counter_chk
// Property checker for tod_counter, attached through bind.
// Assumes all inputs are synchronous to clk.
module tod_counter_chk
    import tod_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic count_en,
    input logic clear,
    input logic mode_24,
    input logic set_mode,
    input bcd_t sec_ones,
    input bcd_t sec_tens,
    input bcd_t min_ones,
    input bcd_t min_tens,
    input bcd_t hr_ones,
    input bcd_t hr_tens,
    input logic hour_pulse
);
    logic [7:0] hr_val;
    logic [23:0] all_digits;

    assign hr_val     = 8'(hr_tens) * 8'd10 + 8'(hr_ones);
    assign all_digits = {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};

    assert_sec_min_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sec_ones <= 4'd9 && sec_tens <= 4'd5 && min_ones <= 4'd9 && min_tens <= 4'd5);

    assert_hour_range_24_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_24 |-> (hr_ones <= 4'd9 && hr_val <= 8'd23));

    assert_hour_range_12_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_24 |-> (hr_ones <= 4'd9 && hr_val >= 8'd1 && hr_val <= 8'd12));

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clear) && $past(rst_n)) |->
            (sec_ones == 4'd0 && sec_tens == 4'd0 && min_ones == 4'd0 && min_tens == 4'd0
             && (hr_val == 8'd0 || hr_val == 8'd12)));

    assert_frozen_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(count_en) && !$past(clear) && $stable(mode_24)) |->
            $stable(all_digits));

    assert_pulse_at_hour_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hour_pulse |-> (min_ones == 4'd0 && min_tens == 4'd0 && sec_ones == 4'd0
                        && sec_tens == 4'd0 && !$past(set_mode)));

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hour_pulse |=> !hour_pulse);
endmodule

bind tod_counter tod_counter_chk u_chk (.*);

// File: tb/tb_tod_counter.sv
// Directed bench for tod_counter: one task per scenario, each checking itself.
module tb_tod_counter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1hz = 1'b0;
    logic count_en = 1'b1;
    logic clear = 1'b0;
    logic mode_24 = 1'b1;
    logic set_mode = 1'b0;
    logic btn_min = 1'b0;
    logic btn_hour = 1'b0;
    logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;
    logic hour_pulse;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    // Bench model of stored time; hour is 0..23.
    int eh = 0, em = 0, es = 0;
    bit exp_pulse = 1'b0;

    always #2 clk = ~clk;

    tod_counter dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .count_en(count_en),
        .clear(clear), .mode_24(mode_24), .set_mode(set_mode),
        .btn_min(btn_min), .btn_hour(btn_hour),
        .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
        .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens),
        .hour_pulse(hour_pulse)
    );

    function automatic int shown_hour(int h, bit m24);
        int v;
        if (m24) return h;
        v = h % 12;
        return (v == 0) ? 12 : v;
    endfunction

    task automatic check(string req, int act, int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic check_time(string req);
        int act_t, exp_t;
        act_t = (hr_tens * 10 + hr_ones) * 10000 + (min_tens * 10 + min_ones) * 100
                + sec_tens * 10 + sec_ones;
        exp_t = shown_hour(eh, mode_24) * 10000 + em * 100 + es;
        check(req, act_t, exp_t);
    endtask

    task automatic tick_once();
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) tick_1hz = 1'b0;
        exp_pulse = 1'b0;
        if (count_en) begin
            es++;
            if (es == 60) begin
                es = 0;
                if (!set_mode) begin
                    em++;
                    if (em == 60) begin
                        em = 0;
                        eh = (eh + 1) % 24;
                        exp_pulse = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic press(bit hour_btn);
        @(negedge clk);
        if (hour_btn) btn_hour = 1'b1; else btn_min = 1'b1;
        repeat (4) @(negedge clk);
        btn_hour = 1'b0;
        btn_min = 1'b0;
        repeat (4) @(negedge clk);
        if (count_en && set_mode) begin
            if (hour_btn) eh = (eh + 1) % 24;
            else          em = (em + 1) % 60;
        end
    endtask

    task automatic do_clear();
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
        eh = 0; em = 0; es = 0;
    endtask

    task automatic set_to(int h, int m, int s);
        do_clear();
        set_mode = 1'b1;
        for (int i = 0; i < h; i++) press(1'b1);
        for (int i = 0; i < m; i++) press(1'b0);
        for (int i = 0; i < s; i++) tick_once();
    endtask

    task automatic t_reset();
        check_time("R5 reset digits");
        check("R10 no pulse after reset", int'(hour_pulse), 0);
    endtask

    task automatic t_counting();
        for (int i = 0; i < 12; i++) tick_once();
        check("R1 seconds units carry", sec_tens * 10 + sec_ones, 12);
        check_time("R1 twelve ticks");
        for (int i = 0; i < 48; i++) tick_once();
        check_time("R1 seconds wrap carries to minutes");
        check("R1 minute is one", min_tens * 10 + min_ones, 1);
    endtask

    task automatic t_set_buttons();
        set_mode = 1'b1;
        press(1'b0); press(1'b0); press(1'b0);
        check_time("R7 three minute presses, held four cycles each");
        press(1'b1);
        check_time("R7 one hour press");
        for (int i = 0; i < 60; i++) tick_once();
        check_time("R8 seconds wrap in set mode does not carry");
        set_mode = 1'b0;
    endtask

    task automatic t_run_buttons();
        press(1'b0);
        press(1'b1);
        check_time("R9 buttons ignored in run mode");
    endtask

    task automatic t_disabled();
        count_en = 1'b0;
        tick_once();
        set_mode = 1'b1;
        press(1'b0);
        press(1'b1);
        check_time("R6 frozen while disabled");
        set_mode = 1'b0;
        count_en = 1'b1;
    endtask

    task automatic t_roll_24();
        mode_24 = 1'b1;
        set_to(23, 59, 59);
        check_time("R2 set to 23:59:59");
        set_mode = 1'b0;
        tick_once();
        check("R2 wrap to midnight", (hr_tens * 10 + hr_ones) * 10000
              + (min_tens * 10 + min_ones) * 100 + sec_tens * 10 + sec_ones, 0);
        check("R10 pulse at top of hour", int'(hour_pulse), int'(exp_pulse));
        @(negedge clk);
        check("R10 pulse lasts one cycle", int'(hour_pulse), 0);
    endtask

    task automatic t_manual_wraps();
        set_to(5, 59, 0);
        press(1'b0);
        check_time("R8 manual minute 59 to 00 keeps hour");
        check("R8 hour stays 5", hr_tens * 10 + hr_ones, 5);
        set_to(23, 0, 0);
        press(1'b1);
        check("R8 manual hour 23 to 00", hr_tens * 10 + hr_ones, 0);
        set_mode = 1'b0;
    endtask

    task automatic t_roll_12();
        mode_24 = 1'b0;
        do_clear();
        check("R5 midnight shows 12 in 12-hour mode", hr_tens * 10 + hr_ones, 12);
        set_to(11, 59, 59);
        set_mode = 1'b0;
        tick_once();
        check("R3 11:59:59 rolls to 12", hr_tens * 10 + hr_ones, 12);
        check_time("R3 noon");
        check("R10 pulse at noon", int'(hour_pulse), 1);
        set_mode = 1'b1;
        for (int i = 0; i < 59; i++) press(1'b0);
        for (int i = 0; i < 59; i++) tick_once();
        set_mode = 1'b0;
        tick_once();
        check("R3 12:59:59 rolls to 01", hr_tens * 10 + hr_ones, 1);
        check_time("R3 one o'clock");
    endtask

    task automatic t_mode_switch();
        @(negedge clk) mode_24 = 1'b1;
        #1;
        check("R4 stored 13 on 24-hour dial", hr_tens * 10 + hr_ones, 13);
        @(negedge clk) mode_24 = 1'b0;
        #1;
        check("R4 stored 13 on 12-hour dial", hr_tens * 10 + hr_ones, 1);
        mode_24 = 1'b1;
    endtask

    task automatic t_set_no_pulse();
        set_to(7, 59, 59);
        tick_once();
        check("R10 no pulse in set mode", int'(hour_pulse), 0);
        check_time("R8 set-mode wrap at 59:59");
        set_mode = 1'b0;
    endtask

    task automatic t_clear_priority();
        tick_once();
        @(negedge clk) begin clear = 1'b1; tick_1hz = 1'b1; end
        @(negedge clk) begin clear = 1'b0; tick_1hz = 1'b0; end
        eh = 0; em = 0; es = 0;
        check_time("R5 clear beats tick");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counting();
        t_set_buttons();
        t_run_buttons();
        t_disabled();
        t_roll_24();
        t_manual_wraps();
        t_roll_12();
        t_mode_switch();
        t_set_no_pulse();
        t_clear_priority();
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule